// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides whether an incoming Ethernet frame is kept. Once the destination address, the frame length and the result of the CRC check are known, the receive path presents them with a one-cycle `frameValid` strobe. The filter then answers one clock later with an accept decision, a `done` pulse and a small set of status bits.

The decision combines several rules. Unicast frames pass when the destination exactly matches the station address, or when promiscuous mode is on. The all-ones broadcast address has its own enable. Other group addresses are looked up in a 64-entry hash table. Two further enables control whether runt frames and frames with CRC or alignment errors are kept. The status bits tell software whether a group address caused the acceptance, and whether a CRC or alignment error was seen.

The station address, the hash table and the five mode enables come in as plain inputs from a register file outside the block. Frame buffering and CRC generation belong to other blocks.

Top module: `rx_addr_filter`

## Requirements
- R1: While `rstN` is low, and after it is released until the first strobe, `done`, `accept`, `groupHit`, `crcErrFlag` and `alignErrFlag` are all 0.
- R2: A `frameValid` high on one rising edge captures the inputs. Its results appear on the outputs after that same edge, with `done` high for exactly that one cycle (it stays high over back-to-back strobes). Without a strobe the outputs hold their last values, and changes on the other inputs have no effect.
- R3: A destination with bit 0 of byte 0 clear is physical. Byte i of an address sits at bits [8i+7:8i], and byte 0 is the first byte received. A physical destination is accepted when all six bytes equal `stationAddr`, or for any value when `promisc` is 1.
- R4: The all-ones destination is accepted only when `acceptBcast` is 1. The hash table is never consulted for it, so with `acceptBcast` at 0 it is rejected even if its hash bit is set and `acceptMcast` is 1.
- R5: A group destination other than broadcast (bit 0 of byte 0 set) is accepted only when `acceptMcast` is 1 and its hash bit is set. `promisc` has no effect on group destinations.
- R6: The hash index is computed as follows:
  - Run CRC-32 with polynomial 0x04C11DB7 over the 48 destination bits.
  - Feed the bits least significant bit first, starting from byte 0.
  - Start the shift register at all ones and apply no final inversion.
  - Take the index from the CRC's top 6 bits [31:26].
  - The selected bit is `hashTable[index]`: register `index[5:3]` is `hashTable[8k+7:8k]`, and `index[2:0]` picks the bit within it.
- R7: A frame whose length is below MIN_LEN (64) is rejected unless `acceptRunt` is 1. A length of exactly 64 is not a runt.
- R8: A frame with `crcBad` or `alignBad` set is rejected unless `saveErrored` is 1.
- R9: `groupHit` is 1 only when the frame is accepted and its destination is a group address (broadcast included). It is 0 for accepted physical frames and for rejected frames.
- R10: `crcErrFlag` is `crcBad` OR `alignBad`, and `alignErrFlag` is `alignBad`. Both are reported whether or not the frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameValid | input | 1 | One-cycle strobe: frame information is valid |
| destAddr | input | 48 | Destination address, byte 0 at bits [7:0] |
| frameLen | input | LEN_W (11) | Frame length in bytes |
| crcBad | input | 1 | Frame failed its CRC check |
| alignBad | input | 1 | Frame ended off a byte boundary |
| stationAddr | input | 48 | Own station address, same byte order as destAddr |
| hashTable | input | 64 | Multicast hash bits, eight 8-bit registers |
| saveErrored | input | 1 | Keep frames with CRC or alignment errors |
| acceptRunt | input | 1 | Keep frames shorter than MIN_LEN |
| acceptBcast | input | 1 | Accept the broadcast address |
| acceptMcast | input | 1 | Accept group addresses that hit the hash table |
| promisc | input | 1 | Accept every physical destination |
| done | output | 1 | One-cycle pulse: decision is valid |
| accept | output | 1 | Frame is kept |
| groupHit | output | 1 | Acceptance came from a group address |
| crcErrFlag | output | 1 | CRC error status (also set on alignment error) |
| alignErrFlag | output | 1 | Alignment error status |

## Verification
The hardest case to reach from the ports is a multicast frame whose acceptance hinges on one single hash bit. Because the index is a CRC of the address, no fixed table content targets it. The bench therefore computes the index itself, with a reflected CRC formulation that is independent of the design. It then loads a table with only that bit set, and separately a table with every bit except that one. The broadcast-priority case is reached by pairing the all-ones address with a fully set table and broadcast disabled.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int ADDR_BYTES   = 6;
  localparam int ADDR_W       = 8 * ADDR_BYTES;
  localparam int HASH_BITS    = 6;
  localparam int HASH_ENTRIES = 1 << HASH_BITS;
  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
  } rxfCtl_t;

  // CRC-32 over the address, least significant bit first, no final inversion;
  // only the top HASH_BITS bits are returned
  function automatic logic [HASH_BITS-1:0] hashIndex(input logic [ADDR_W-1:0] addr);
    logic [31:0] crc;
    logic fb;
    crc = '1;
    for (int i = 0; i < ADDR_W; i++) begin
      fb  = crc[31] ^ addr[i];
      crc = {crc[30:0], 1'b0};
      if (fb) crc = crc ^ CRC_POLY;
    end
    return crc[31 -: HASH_BITS];
  endfunction
endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    frameValid,
  output rxfCtl_t ctl,
  output logic    done
);
  always_comb begin
    ctl      = '0;
    ctl.load = frameValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) done <= 1'b0;
    else       done <= frameValid;
  end
endmodule

// File: rtl/rxf_datapath.sv
module rxf_datapath
  import rxf_pkg::*;
#(
  parameter int LEN_W   = 11,
  parameter int MIN_LEN = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  rxfCtl_t                 ctl,
  input  logic [ADDR_W-1:0]       destAddr,
  input  logic [LEN_W-1:0]        frameLen,
  input  logic                    crcBad,
  input  logic                    alignBad,
  input  logic [ADDR_W-1:0]       stationAddr,
  input  logic [HASH_ENTRIES-1:0] hashTable,
  input  logic                    saveErrored,
  input  logic                    acceptRunt,
  input  logic                    acceptBcast,
  input  logic                    acceptMcast,
  input  logic                    promisc,
  output logic                    accept,
  output logic                    groupHit,
  output logic                    crcErrFlag,
  output logic                    alignErrFlag
);
  localparam logic [LEN_W-1:0] MIN_LEN_V = LEN_W'(MIN_LEN);

  logic [ADDR_BYTES-1:0] byteEq;
  logic                  stationHit;
  logic                  isGroup;
  logic                  isBcast;
  logic [HASH_BITS-1:0]  hIdx;
  logic                  hashHit;
  logic                  addrOk;
  logic                  lenOk;
  logic                  errOk;
  logic                  acceptNext;

  // per-byte station compare
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : gByte
    assign byteEq[g] = (destAddr[8*g +: 8] == stationAddr[8*g +: 8]);
  end

  assign stationHit = &byteEq;
  assign isGroup    = destAddr[0];
  assign isBcast    = &destAddr;
  assign hIdx       = hashIndex(destAddr);
  assign hashHit    = hashTable[hIdx];

  always_comb begin
    if (isBcast)      addrOk = acceptBcast;
    else if (isGroup) addrOk = acceptMcast & hashHit;
    else              addrOk = promisc | stationHit;
  end

  assign lenOk      = (frameLen >= MIN_LEN_V) | acceptRunt;
  assign errOk      = ~(crcBad | alignBad) | saveErrored;
  assign acceptNext = addrOk & lenOk & errOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accept       <= 1'b0;
      groupHit     <= 1'b0;
      crcErrFlag   <= 1'b0;
      alignErrFlag <= 1'b0;
    end else if (ctl.load) begin
      accept       <= acceptNext;
      groupHit     <= acceptNext & isGroup;
      crcErrFlag   <= crcBad | alignBad;
      alignErrFlag <= alignBad;
    end
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int LEN_W   = 11,
  parameter int MIN_LEN = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    frameValid,
  input  logic [ADDR_W-1:0]       destAddr,
  input  logic [LEN_W-1:0]        frameLen,
  input  logic                    crcBad,
  input  logic                    alignBad,
  input  logic [ADDR_W-1:0]       stationAddr,
  input  logic [HASH_ENTRIES-1:0] hashTable,
  input  logic                    saveErrored,
  input  logic                    acceptRunt,
  input  logic                    acceptBcast,
  input  logic                    acceptMcast,
  input  logic                    promisc,
  output logic                    done,
  output logic                    accept,
  output logic                    groupHit,
  output logic                    crcErrFlag,
  output logic                    alignErrFlag
);
  rxfCtl_t ctl;

  rxf_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .frameValid (frameValid),
    .ctl        (ctl),
    .done       (done)
  );

  rxf_datapath #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .destAddr     (destAddr),
    .frameLen     (frameLen),
    .crcBad       (crcBad),
    .alignBad     (alignBad),
    .stationAddr  (stationAddr),
    .hashTable    (hashTable),
    .saveErrored  (saveErrored),
    .acceptRunt   (acceptRunt),
    .acceptBcast  (acceptBcast),
    .acceptMcast  (acceptMcast),
    .promisc      (promisc),
    .accept       (accept),
    .groupHit     (groupHit),
    .crcErrFlag   (crcErrFlag),
    .alignErrFlag (alignErrFlag)
  );
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int LEN_W   = 11,
  parameter int MIN_LEN = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameValid,
  input logic [LEN_W-1:0] frameLen,
  input logic             crcBad,
  input logic             alignBad,
  input logic             saveErrored,
  input logic             acceptRunt,
  input logic             done,
  input logic             accept,
  input logic             groupHit,
  input logic             crcErrFlag,
  input logic             alignErrFlag
);
  localparam logic [LEN_W-1:0] MIN_LEN_V = LEN_W'(MIN_LEN);

  // R2
  done_after_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |=> done);

  // R2
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameValid |=> !done);

  // R2
  hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameValid |=> ($stable(accept) && $stable(groupHit) && $stable(crcErrFlag)));

  // R7
  runt_rule_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && accept) |-> (($past(frameLen) >= MIN_LEN_V) || $past(acceptRunt)));

  // R8
  err_rule_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && accept) |-> (!($past(crcBad) || $past(alignBad)) || $past(saveErrored)));

  // R9
  group_needs_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    groupHit |-> accept);

  // R10
  align_implies_crc_chk: assert property (@(posedge clk) disable iff (!rstN)
    alignErrFlag |-> crcErrFlag);
endmodule

bind rx_addr_filter rxf_checker #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .frameValid   (frameValid),
  .frameLen     (frameLen),
  .crcBad       (crcBad),
  .alignBad     (alignBad),
  .saveErrored  (saveErrored),
  .acceptRunt   (acceptRunt),
  .done         (done),
  .accept       (accept),
  .groupHit     (groupHit),
  .crcErrFlag   (crcErrFlag),
  .alignErrFlag (alignErrFlag)
);

// File: tb/rx_addr_filter_tb_top.sv
`timescale 1ns/1ps
module rx_addr_filter_tb_top;
  localparam int LEN_W = 11;
  localparam logic [47:0] STA = 48'h6655_4433_2210;
  localparam logic [47:0] MIS = 48'h6655_4433_2310;
  localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MC  = 48'h0A0B_0C0D_0E01;
  // cfg = {promisc, acceptMcast, acceptBcast, acceptRunt, saveErrored}
  localparam logic [4:0] C0 = 5'b00000, CP = 5'b10000, CM = 5'b01000,
                         CB = 5'b00100, CR = 5'b00010, CS = 5'b00001;

  typedef struct packed {
    logic [47:0] dest;
    logic [10:0] len;
    logic        crcB;
    logic        alignB;
    logic [4:0]  cfg;
    logic [1:0]  hMode;   // 0 zeros, 1 ones, 2 only own bit, 3 all but own bit
    logic        expAcc;
    logic        expGrp;
    logic        expCrc;
    logic        expAlign;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{STA, 11'd64,  1'b0, 1'b0, C0,      2'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 R7 exact 64
    '{MIS, 11'd100, 1'b0, 1'b0, C0,      2'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 mismatch
    '{MIS, 11'd100, 1'b0, 1'b0, CP,      2'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 promisc
    '{BC,  11'd100, 1'b0, 1'b0, CB,      2'd0, 1'b1, 1'b1, 1'b0, 1'b0}, // R4
    '{BC,  11'd100, 1'b0, 1'b0, C0,      2'd1, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 off
    '{BC,  11'd100, 1'b0, 1'b0, CM,      2'd1, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 priority
    '{MC,  11'd100, 1'b0, 1'b0, CM,      2'd2, 1'b1, 1'b1, 1'b0, 1'b0}, // R5 R6 hit
    '{MC,  11'd100, 1'b0, 1'b0, CM,      2'd3, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 miss
    '{MC,  11'd100, 1'b0, 1'b0, C0,      2'd1, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 mcast off
    '{MC,  11'd100, 1'b0, 1'b0, CP,      2'd1, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 promisc no effect
    '{STA, 11'd63,  1'b0, 1'b0, C0,      2'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 runt
    '{STA, 11'd63,  1'b0, 1'b0, CR,      2'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // R7 keep runt
    '{STA, 11'd100, 1'b1, 1'b0, C0,      2'd0, 1'b0, 1'b0, 1'b1, 1'b0}, // R8 R10
    '{STA, 11'd100, 1'b1, 1'b0, CS,      2'd0, 1'b1, 1'b0, 1'b1, 1'b0}, // R8 save
    '{STA, 11'd100, 1'b0, 1'b1, CS,      2'd0, 1'b1, 1'b0, 1'b1, 1'b1}, // R8 R10 align
    '{STA, 11'd100, 1'b0, 1'b1, C0,      2'd0, 1'b0, 1'b0, 1'b1, 1'b1}, // R8 align drop
    '{MC,  11'd20,  1'b0, 1'b0, CM | CR, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0}  // R5 R7 R9
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameValid = 1'b0;
  logic [47:0] destAddr = '0;
  logic [LEN_W-1:0] frameLen = '0;
  logic crcBad = 1'b0, alignBad = 1'b0;
  logic [47:0] stationAddr = STA;
  logic [63:0] hashTable = '0;
  logic saveErrored = 1'b0, acceptRunt = 1'b0, acceptBcast = 1'b0;
  logic acceptMcast = 1'b0, promisc = 1'b0;
  logic done, accept, groupHit, crcErrFlag, alignErrFlag;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rx_addr_filter dut_i (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .destAddr(destAddr),
    .frameLen(frameLen), .crcBad(crcBad), .alignBad(alignBad),
    .stationAddr(stationAddr), .hashTable(hashTable), .saveErrored(saveErrored),
    .acceptRunt(acceptRunt), .acceptBcast(acceptBcast), .acceptMcast(acceptMcast),
    .promisc(promisc), .done(done), .accept(accept), .groupHit(groupHit),
    .crcErrFlag(crcErrFlag), .alignErrFlag(alignErrFlag)
  );

  // reflected CRC-32; bit-reversing its low bits gives the top bits of the R6 form
  function automatic logic [5:0] benchIdx(input logic [47:0] a);
    logic [31:0] r;
    logic lsb;
    r = '1;
    for (int i = 0; i < 48; i++) begin
      lsb = r[0] ^ a[i];
      r = r >> 1;
      if (lsb) r = r ^ 32'hEDB8_8320;
    end
    return {r[0], r[1], r[2], r[3], r[4], r[5]};
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  task automatic applyVec(input vec_t v);
    logic [5:0] idx;
    idx = benchIdx(v.dest);
    @(negedge clk);
    destAddr = v.dest;
    frameLen = v.len;
    crcBad = v.crcB;
    alignBad = v.alignB;
    {promisc, acceptMcast, acceptBcast, acceptRunt, saveErrored} = v.cfg;
    case (v.hMode)
      2'd0: hashTable = '0;
      2'd1: hashTable = '1;
      2'd2: hashTable = 64'd1 << idx;
      default: hashTable = ~(64'd1 << idx);
    endcase
    frameValid = 1'b1;
    @(negedge clk);
    frameValid = 1'b0;
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1", "done", done, 1'b0);
    chk("R1", "accept", accept, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "groupHit", groupHit, 1'b0);
    chk("R1", "crcErrFlag", crcErrFlag, 1'b0);
    chk("R1", "alignErrFlag", alignErrFlag, 1'b0);

    for (int k = 0; k < NV; k++) begin
      applyVec(VEC[k]);
      chk("R2", $sformatf("vec%0d done", k), done, 1'b1);
      chk("R3-R8", $sformatf("vec%0d accept", k), accept, VEC[k].expAcc);
      chk("R9", $sformatf("vec%0d groupHit", k), groupHit, VEC[k].expGrp);
      chk("R10", $sformatf("vec%0d crcErrFlag", k), crcErrFlag, VEC[k].expCrc);
      chk("R10", $sformatf("vec%0d alignErrFlag", k), alignErrFlag, VEC[k].expAlign);
      @(negedge clk);
      chk("R2", $sformatf("vec%0d done falls", k), done, 1'b0);
    end

    // R2: input changes without a strobe are ignored
    applyVec(VEC[3]);      // broadcast accepted, group
    destAddr = MIS;
    acceptBcast = 1'b0;
    crcBad = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2", "hold accept", accept, 1'b1);
    chk("R2", "hold groupHit", groupHit, 1'b1);
    chk("R2", "hold crcErrFlag", crcErrFlag, 1'b0);
    chk("R2", "hold done", done, 1'b0);

    // R2: back-to-back strobes keep done high, second result wins
    @(negedge clk);
    destAddr = STA; frameLen = 11'd100; crcBad = 1'b0; alignBad = 1'b0;
    {promisc, acceptMcast, acceptBcast, acceptRunt, saveErrored} = C0;
    frameValid = 1'b1;
    @(negedge clk);
    chk("R2", "b2b first done", done, 1'b1);
    chk("R3", "b2b first accept", accept, 1'b1);
    destAddr = MIS;
    @(negedge clk);
    frameValid = 1'b0;
    chk("R2", "b2b second done", done, 1'b1);
    chk("R3", "b2b second accept", accept, 1'b0);

    // R1: reset mid-run clears results
    applyVec(VEC[0]);
    rstN = 1'b0;
    @(negedge clk);
    chk("R1", "reset accept", accept, 1'b0);
    chk("R1", "reset done", done, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule